// File: doc/BRIEF.md
# Compare-Event PWM Channel

This block is a single pulse-width modulation channel with two outputs, A and B, timed by an up-counting ramp. The ramp counts clock cycles from zero up to a programmed terminal count and then returns to zero. Each output has its own rise and fall event. The fall event of each output is moved by a signed cycle-adjust offset, which lets a controller trim the two pulse widths independently. Two strobes derived from the ramp leave the channel. One is a phase strobe that can restart a second channel for interleaved operation. The other is a sample strobe that tells a converter when to sample.

Software programs the channel through a simple write port. Timing values go into a staging copy. The running copy takes them over only when the ramp wraps or an external restart arrives, so a ramp cycle never runs on a mix of old and new settings. An edge time pushed outside the ramp by its adjust is clamped into range. This keeps the outputs free of glitches. Polarity selection and the run enable act at once. While the channel is stopped, every output is held low.

Top module: `evpwm_chan`

## Requirements
- R1: While running, the ramp counts 0, 1, ..., P and wraps, where P is the running terminal count (P = 0 keeps the ramp at 0). Each registered output in a given clock cycle reflects the ramp value of the previous cycle.
- R2: A terminal count written while running goes to the staging copy. It takes effect from the first ramp value 0 after the ramp next wraps, or from the first value 0 after a restart.
- R3: Raw output A is active while rise_A <= count < fall_A. Here rise_A is the coarse A-rise event and fall_A is the coarse A-fall event plus the coarse part of adjust A. An event word carries its coarse count in bits [FINE_W+:CNT_W]. The low FINE_W bits of an event word are ignored.
- R4: Raw output B follows the same rule as R3, using the B-rise event, the B-fall event and adjust B.
- R5: An adjust word is a signed ADJ_W-bit two's-complement value. Its coarse part is the value shifted arithmetically right by FINE_W, which rounds toward minus infinity (for example, -20 gives -2).
- R6: An adjusted fall time below 0 is treated as 0, and one above P is treated as P. A rise time above P is treated as P. An output whose clamped fall time is not above its clamped rise time stays inactive for the whole cycle.
- R7: Event, adjust, phase and sample registers are staged in the same way as the terminal count (R2).
- R8: A high sync_in sampled at a clock edge sets the ramp to 0 and loads the staging copy. The output two cycles after the sync cycle reflects count 0.
- R9: sync_out is a one-cycle pulse for each ramp value equal to the running phase count.
- R10: sample_trig is a one-cycle pulse for each ramp value equal to the running sample count.
- R11: Control word bit 1 (output A) and bit 2 (output B) select active-low polarity, which inverts the raw output. They take effect from the next edge and are not staged.
- R12: After reset, and whenever control bit 0 (run) is clear, the ramp is held at 0, all four outputs are low, and the staging copy passes straight to the running copy.
- R13: Write addresses are 0 control, 1 terminal count, 2 A-rise, 3 A-fall, 4 B-rise, 5 B-fall, 6 adjust A, 7 adjust B, 8 phase count, 9 sample count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock, one ramp step per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (see R13) |
| wr_data | input | max(CNT_W+FINE_W, ADJ_W) | Register write data |
| sync_in | input | 1 | Ramp restart request |
| sync_out | output | 1 | Phase strobe for slaving another channel |
| sample_trig | output | 1 | Sample strobe |
| pwm_a | output | 1 | Output A after polarity |
| pwm_b | output | 1 | Output B after polarity |

## Verification
The bench builds the channel with CNT_W = 6, FINE_W = 4 and ADJ_W = 16. At this size the full 64-value ramp, including the largest terminal count, can be swept cycle by cycle in a few hundred clocks, and a terminal count of 0 is cheap to cover. With the narrow counter, large positive and negative adjusts push fall edges well past both ends of the ramp, which exercises every clamp path. Writes in the middle of a cycle and restarts at chosen ramp values are placed so that the staging boundary sits inside the observed window.

// File: rtl/evpwm_pkg.sv
package evpwm_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] RA_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] RA_TERM   = 4'd1;
    localparam logic [ADDR_W-1:0] RA_A_RISE = 4'd2;
    localparam logic [ADDR_W-1:0] RA_A_FALL = 4'd3;
    localparam logic [ADDR_W-1:0] RA_B_RISE = 4'd4;
    localparam logic [ADDR_W-1:0] RA_B_FALL = 4'd5;
    localparam logic [ADDR_W-1:0] RA_ADJ_A  = 4'd6;
    localparam logic [ADDR_W-1:0] RA_ADJ_B  = 4'd7;
    localparam logic [ADDR_W-1:0] RA_PHASE  = 4'd8;
    localparam logic [ADDR_W-1:0] RA_SAMPLE = 4'd9;

    // control word: bit0 run, bit1 A active-low, bit2 B active-low
    typedef struct packed {
        logic inv_b;
        logic inv_a;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/evpwm_regs.sv
module evpwm_regs
    import evpwm_pkg::*;
#(
    parameter int CNT_W  = 14,
    parameter int FINE_W = 4,
    parameter int ADJ_W  = 16,
    parameter int DATA_W = 18
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        load,
    output ctrl_t                       ctrl,
    output logic [CNT_W-1:0]            term,
    output logic [1:0][CNT_W-1:0]       rise,
    output logic [1:0][CNT_W-1:0]       fall,
    output logic [1:0][ADJ_W-1:0]       adj,
    output logic [CNT_W-1:0]            phase,
    output logic [CNT_W-1:0]            smp
);

    typedef struct packed {
        logic [CNT_W-1:0]      term;
        logic [1:0][CNT_W-1:0] rise;
        logic [1:0][CNT_W-1:0] fall;
        logic [1:0][ADJ_W-1:0] adj;
        logic [CNT_W-1:0]      phase;
        logic [CNT_W-1:0]      smp;
    } tset_t;

    typedef struct packed {
        ctrl_t ctrl;
        tset_t stg;
        tset_t run;
    } st_t;

    st_t st_d, st_q;

    logic [CNT_W-1:0] coarse_w;
    assign coarse_w = wr_data[FINE_W +: CNT_W];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (wr_addr)
                RA_CTRL:   st_d.ctrl         = ctrl_t'(wr_data[2:0]);
                RA_TERM:   st_d.stg.term     = wr_data[CNT_W-1:0];
                RA_A_RISE: st_d.stg.rise[0]  = coarse_w;
                RA_A_FALL: st_d.stg.fall[0]  = coarse_w;
                RA_B_RISE: st_d.stg.rise[1]  = coarse_w;
                RA_B_FALL: st_d.stg.fall[1]  = coarse_w;
                RA_ADJ_A:  st_d.stg.adj[0]   = wr_data[ADJ_W-1:0];
                RA_ADJ_B:  st_d.stg.adj[1]   = wr_data[ADJ_W-1:0];
                RA_PHASE:  st_d.stg.phase    = wr_data[CNT_W-1:0];
                RA_SAMPLE: st_d.stg.smp      = wr_data[CNT_W-1:0];
                default:   st_d.ctrl         = st_q.ctrl;
            endcase
        end
        // boundary takes the staging copy as it stood before this edge
        if (load) begin
            st_d.run = st_q.stg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl  = st_q.ctrl;
    assign term  = st_q.run.term;
    assign rise  = st_q.run.rise;
    assign fall  = st_q.run.fall;
    assign adj   = st_q.run.adj;
    assign phase = st_q.run.phase;
    assign smp   = st_q.run.smp;

endmodule

// File: rtl/evpwm_timebase.sv
module evpwm_timebase #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [CNT_W-1:0] term,
    output logic [CNT_W-1:0] cnt,
    output logic             load
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        load  = !run || restart || (cnt_q == term);
        cnt_d = load ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/evpwm_edge.sv
module evpwm_edge #(
    parameter int CNT_W  = 14,
    parameter int FINE_W = 4,
    parameter int ADJ_W  = 16
) (
    input  logic [CNT_W-1:0] term,
    input  logic [CNT_W-1:0] rise,
    input  logic [CNT_W-1:0] fall,
    input  logic [ADJ_W-1:0] adj,
    input  logic [CNT_W-1:0] cnt,
    output logic             active
);

    localparam int SH_W  = ADJ_W - FINE_W;
    localparam int SUM_W = ((CNT_W > SH_W) ? CNT_W : SH_W) + 2;

    logic signed [ADJ_W-1:0] adj_sh;
    logic signed [SUM_W-1:0] fall_sum;
    logic signed [SUM_W-1:0] term_s;
    logic [CNT_W-1:0]        fall_cl;
    logic [CNT_W-1:0]        rise_cl;

    always_comb begin
        adj_sh   = $signed(adj) >>> FINE_W;
        term_s   = SUM_W'($signed({1'b0, term}));
        fall_sum = SUM_W'($signed({1'b0, fall})) + SUM_W'(adj_sh);
        if (fall_sum < 0) begin
            fall_cl = '0;
        end else if (fall_sum > term_s) begin
            fall_cl = term;
        end else begin
            fall_cl = fall_sum[CNT_W-1:0];
        end
        rise_cl = (rise > term) ? term : rise;
        active  = (cnt >= rise_cl) && (cnt < fall_cl);
    end

endmodule

// File: rtl/evpwm_chan.sv
module evpwm_chan
    import evpwm_pkg::*;
#(
    parameter int  CNT_W  = 14,
    parameter int  FINE_W = 4,
    parameter int  ADJ_W  = 16,
    localparam int DATA_W = ((CNT_W + FINE_W) > ADJ_W) ? (CNT_W + FINE_W) : ADJ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sync_in,
    output logic              sync_out,
    output logic              sample_trig,
    output logic              pwm_a,
    output logic              pwm_b
);

    localparam int NOUT = 2;

    ctrl_t                    ctrl;
    logic                     run_en;
    logic [CNT_W-1:0]         term;
    logic [NOUT-1:0][CNT_W-1:0] rise;
    logic [NOUT-1:0][CNT_W-1:0] fall;
    logic [NOUT-1:0][ADJ_W-1:0] adj;
    logic [CNT_W-1:0]         phase;
    logic [CNT_W-1:0]         smp;
    logic [CNT_W-1:0]         cnt;
    logic                     load;
    logic [NOUT-1:0]          win;
    logic [NOUT-1:0]          inv;

    assign run_en = ctrl.run;
    assign inv    = {ctrl.inv_b, ctrl.inv_a};

    evpwm_regs #(
        .CNT_W (CNT_W),
        .FINE_W(FINE_W),
        .ADJ_W (ADJ_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .load   (load),
        .ctrl   (ctrl),
        .term   (term),
        .rise   (rise),
        .fall   (fall),
        .adj    (adj),
        .phase  (phase),
        .smp    (smp)
    );

    evpwm_timebase #(
        .CNT_W(CNT_W)
    ) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_en),
        .restart(sync_in),
        .term   (term),
        .cnt    (cnt),
        .load   (load)
    );

    for (genvar g = 0; g < NOUT; g++) begin : g_edge
        evpwm_edge #(
            .CNT_W (CNT_W),
            .FINE_W(FINE_W),
            .ADJ_W (ADJ_W)
        ) u_edge (
            .term  (term),
            .rise  (rise[g]),
            .fall  (fall[g]),
            .adj   (adj[g]),
            .cnt   (cnt),
            .active(win[g])
        );
    end

    typedef struct packed {
        logic [NOUT-1:0] pin;
        logic            sync;
        logic            smp;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d      = '0;
        if (run_en) begin
            out_d.pin  = win ^ inv;
            out_d.sync = (cnt == phase);
            out_d.smp  = (cnt == smp);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pwm_a       = out_q.pin[0];
    assign pwm_b       = out_q.pin[1];
    assign sync_out    = out_q.sync;
    assign sample_trig = out_q.smp;

endmodule

// File: rtl/evpwm_chan_chk.sv
module evpwm_chan_chk #(
    parameter int CNT_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             sync_in,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] term,
    input logic [CNT_W-1:0] phase,
    input logic [CNT_W-1:0] smp,
    input logic             pwm_a,
    input logic             pwm_b,
    input logic             sync_out,
    input logic             sample_trig
);

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= term);

    p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sync_in && cnt != term) |=> cnt == $past(cnt) + 1'b1);

    p_term_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sync_in && cnt != term) |=> $stable(term));

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sync_in) |=> cnt == '0);

    p_phase_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt == phase) |=> sync_out);

    p_sample_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt == smp) |=> sample_trig);

    p_idle_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!pwm_a && !pwm_b && !sync_out && !sample_trig));

endmodule

bind evpwm_chan evpwm_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (run_en),
    .sync_in    (sync_in),
    .cnt        (cnt),
    .term       (term),
    .phase      (phase),
    .smp        (smp),
    .pwm_a      (pwm_a),
    .pwm_b      (pwm_b),
    .sync_out   (sync_out),
    .sample_trig(sample_trig)
);

// File: tb/evpwm_chan_tb.sv
module evpwm_chan_tb;

    localparam int CNT_W  = 6;
    localparam int FINE_W = 4;
    localparam int ADJ_W  = 16;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [3:0]        wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              sync_in = 1'b0;
    logic              sync_out, sample_trig, pwm_a, pwm_b;

    int n_chk = 0;
    int n_fail = 0;

    // model of the running configuration
    int P, ra, fa, rb, fb, aa, ab, ph, sm;
    bit ia, ib;

    always #5 clk = ~clk;

    evpwm_chan #(.CNT_W(CNT_W), .FINE_W(FINE_W), .ADJ_W(ADJ_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sync_in(sync_in), .sync_out(sync_out),
        .sample_trig(sample_trig), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int coarse_of(input int v);
        if (v >= 0) return v / 16;
        return -((-v + 15) / 16);
    endfunction

    function automatic bit inwin(input int r, input int f, input int a, input int c);
        int rr = (r > P) ? P : r;
        int ff = f + coarse_of(a);
        if (ff < 0) ff = 0;
        if (ff > P) ff = P;
        return (c >= rr) && (c < ff);
    endfunction

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr[3:0]; wr_data = data[DATA_W-1:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic restart();
        @(negedge clk);
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
    endtask

    task automatic load_cfg(input int fine);
        wr(1, P);
        wr(2, (ra << 4) | fine);
        wr(3, (fa << 4) | fine);
        wr(4, (rb << 4) | fine);
        wr(5, (fb << 4) | fine);
        wr(6, aa & 16'hFFFF);
        wr(7, ab & 16'hFFFF);
        wr(8, ph);
        wr(9, sm);
        restart();
    endtask

    task automatic apply(input int addr, input int data);
        case (addr)
            1: P  = data;
            3: fa = data >> 4;
            default: ;
        endcase
    endtask

    // kind: 0 none, 1 write at act_at, 2 sync at act_at
    task automatic run(input int nobs, input int act_at, input int kind,
                       input int waddr, input int wdata, input string req);
        int c = 0;
        bit pend = (kind == 1);
        for (int j = 0; j < nobs; j++) begin
            bit ea, eb;
            @(negedge clk);
            ea = inwin(ra, fa, aa, c) ^ ia;
            eb = inwin(rb, fb, ab, c) ^ ib;
            check(pwm_a === ea, {req, " pwm_a"}, pwm_a, ea);
            check(pwm_b === eb, {req, " pwm_b"}, pwm_b, eb);
            check(sync_out === (c == ph), "R9 sync_out", sync_out, c == ph);
            check(sample_trig === (c == sm), "R10 sample_trig", sample_trig, c == sm);
            if (kind != 0 && j == act_at) begin
                if (kind == 1) begin
                    wr_en = 1'b1; wr_addr = waddr[3:0]; wr_data = wdata[DATA_W-1:0];
                end else begin
                    sync_in = 1'b1;
                end
            end
            if (kind != 0 && j == act_at + 1) begin
                wr_en = 1'b0; sync_in = 1'b0;
            end
            if ((kind == 2 && j == act_at + 1) || c == P) begin
                c = 0;
                if (pend && j >= act_at + 2) begin
                    apply(waddr, wdata);
                    pend = 1'b0;
                end
            end else begin
                c++;
            end
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R12: reset state
        check(pwm_a === 1'b0, "R12 reset pwm_a", pwm_a, 0);
        check(pwm_b === 1'b0, "R12 reset pwm_b", pwm_b, 0);
        check(sync_out === 1'b0, "R12 reset sync_out", sync_out, 0);
        check(sample_trig === 1'b0, "R12 reset sample_trig", sample_trig, 0);
        // R12: stopped with inverted polarity stays low
        wr(0, 6);
        repeat (3) begin
            @(negedge clk);
            check(pwm_a === 1'b0 && pwm_b === 1'b0, "R12 stopped inverted", pwm_a, 0);
        end

        ia = 0; ib = 0;
        wr(0, 1);
        // R1 R3 R4 R13: plain windows
        P = 9; ra = 2; fa = 6; rb = 5; fb = 9; aa = 0; ab = 0; ph = 0; sm = 4;
        load_cfg(0);
        run(25, 0, 0, 0, 0, "R3 R4 basic");

        // R3 R5: fine bits ignored, positive and negative adjust
        ra = 1; fa = 5; rb = 1; fb = 8; aa = 35; ab = -20; ph = 7; sm = 2;
        load_cfg(15);
        run(22, 0, 0, 0, 0, "R5 adjust");

        // R6: fall clamped to terminal count, rise beyond terminal count
        ra = 3; fa = 7; aa = 800; rb = 12; fb = 15; ab = 0; ph = 9; sm = 9;
        load_cfg(0);
        run(22, 0, 0, 0, 0, "R6 clamp high");

        // R6: fall pushed below zero, fall before rise
        ra = 0; fa = 3; aa = -1600; rb = 4; fb = 2; ab = 0; ph = 1; sm = 3;
        load_cfg(7);
        run(22, 0, 0, 0, 0, "R6 clamp low");

        // R1: largest terminal count, full ramp twice
        P = 63; ra = 60; fa = 63; rb = 0; fb = 1; aa = 0; ab = 16; ph = 63; sm = 0;
        load_cfg(0);
        run(130, 0, 0, 0, 0, "R1 full ramp");

        // R1: terminal count zero
        P = 0; ra = 0; fa = 5; rb = 0; fb = 0; aa = 0; ab = 0; ph = 0; sm = 0;
        load_cfg(0);
        run(6, 0, 0, 0, 0, "R1 zero term");

        // R11: polarity inversion
        P = 9; ra = 2; fa = 6; rb = 5; fb = 9; aa = 0; ab = 0; ph = 3; sm = 4;
        load_cfg(0);
        wr(0, 3);
        ia = 1; ib = 0;
        restart();
        run(12, 0, 0, 0, 0, "R11 invert A");
        wr(0, 7);
        ia = 1; ib = 1;
        restart();
        run(12, 0, 0, 0, 0, "R11 invert both");
        wr(0, 1);
        ia = 0; ib = 0;

        // R7: event written mid-cycle waits for the wrap
        restart();
        run(25, 3, 1, 3, (8 << 4), "R7 staged event");

        // R2: terminal count written mid-cycle waits for the wrap
        P = 9; fa = 6;
        load_cfg(0);
        run(25, 3, 1, 1, 5, "R2 staged term");

        // R8: restart in mid-cycle
        P = 9; ra = 2; fa = 6; rb = 5; fb = 9; ph = 0; sm = 4;
        load_cfg(0);
        run(25, 5, 2, 0, 0, "R8 restart");

        // R12: stopping forces outputs low
        wr(0, 0);
        repeat (4) begin
            @(negedge clk);
            check(pwm_a === 1'b0 && pwm_b === 1'b0 && sync_out === 1'b0 && sample_trig === 1'b0,
                  "R12 stopped", pwm_a | pwm_b | sync_out | sample_trig, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule